// File: doc/BRIEF.md
# Serial CRC-8 Code Checker

This block validates a 64-bit device code that arrives over a single-wire link one bit at a time. The first 56 bits (an 8-bit family byte followed by a 48-bit serial number, each byte least significant bit first) are folded into a reflected CRC-8 register with generator x^8 + x^5 + x^4 + 1, seeded with zero. The last 8 bits carry the sender's CRC byte. They are not folded in. Instead they are gathered into a separate compare register, and after the 64th bit the block raises a done flag together with a match flag that reports whether the two bytes agree.

Bits may be presented one per strobe, with idle cycles between them. A whole byte may also be handed over, which a small serializer then feeds into the same path least significant bit first over eight consecutive cycles. A synchronous clear input restarts a frame at any time. The running CRC value is visible at all times, so software or a neighbouring block can also use the block as a plain CRC-8 accumulator.

Top module: `serial_crc_checker`

## Requirements
- R1: After reset `crc_val` is 0, and `done`, `match` and `byte_busy` are 0.
- R2: Each accepted data bit d updates the register as follows: t = crc[0] ^ d, the register shifts right by one, and when t is 1 it is then XORed with 8Ch. The new value is visible on `crc_val` after the clock edge on which the bit is accepted.
- R3: Bits 1 to 56 of a frame (family byte then six serial bytes, each LSB first) are folded into the register, and after the 56th bit `crc_val` equals the CRC-8 of those seven bytes.
- R4: Bits 57 to 64 leave `crc_val` unchanged. They are collected LSB first as the received CRC byte.
- R5: After the edge that accepts bit 64, `done` is 1, and `match` is 1 exactly when the collected byte equals `crc_val`. `match` is never 1 while `done` is 0.
- R6: Once `done` is 1, further bit or byte inputs are ignored. `crc_val`, `done` and `match` hold until clear or reset.
- R7: `clr` high at a clock edge resets the bit count, `crc_val`, `done`, `match` and the byte serializer. It takes priority over a bit strobe in the same cycle.
- R8: `byte_vld` with `byte_busy` low loads `byte_in`. `byte_busy` is then 1 for exactly 8 cycles, and during these cycles the byte enters the frame LSB first, one bit per cycle.
- R9: While `byte_busy` is 1, `bit_vld` and `byte_vld` are ignored.
- R10: With no strobe, no clear and the serializer idle, `crc_val`, `done` and `match` do not change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clr | input | 1 | Synchronous frame restart |
| bit_vld | input | 1 | Strobe: `bit_in` carries the next frame bit |
| bit_in | input | 1 | Serial data bit |
| byte_vld | input | 1 | Strobe: load `byte_in` into the serializer |
| byte_in | input | 8 | Byte to feed LSB first |
| byte_busy | output | 1 | Serializer is emitting a byte |
| crc_val | output | 8 | Running CRC register |
| done | output | 1 | All 64 frame bits received |
| match | output | 1 | Received CRC byte equals computed CRC |

## Verification
The assertions check the following on every cycle:
- reset and clear return the block to zero;
- `match` never shows without `done`;
- the flags and the CRC stay frozen once the frame has ended;
- nothing moves when no input is presented;
- a byte load starts the serializer.

The polynomial arithmetic, the bit ordering and the 56/8 split of the frame can only be shown by the bench scenarios. These scenarios cover:
- a known good code;
- a code with a corrupted CRC byte;
- bitwise and bytewise feeding;
- gaps between bits;
- clearing in the middle of a frame;
- strobes that arrive while the serializer is busy or after the frame has ended.

// File: rtl/swcrc_pkg.sv
package swcrc_pkg;

    localparam int CRC_W       = 8;
    localparam int BYTE_W      = 8;
    localparam int DATA_BITS   = 56;
    localparam int FRAME_BITS  = DATA_BITS + CRC_W;
    localparam logic [CRC_W-1:0] POLY_REFL = 8'h8C;

    typedef struct packed {
        logic vld;
        logic dat;
    } beat_t;

    typedef enum logic [1:0] {
        PH_DATA  = 2'd0,
        PH_CHECK = 2'd1,
        PH_DONE  = 2'd2
    } phase_e;

    function automatic logic [CRC_W-1:0] crc_next(
        input logic [CRC_W-1:0] cur,
        input logic             d,
        input logic [CRC_W-1:0] poly
    );
        logic fb;
        logic [CRC_W-1:0] sh;
        fb = cur[0] ^ d;
        sh = cur >> 1;
        return fb ? (sh ^ poly) : sh;
    endfunction

endpackage

// File: rtl/swcrc_byte_feeder.sv
module swcrc_byte_feeder
    import swcrc_pkg::*;
#(
    parameter int W = BYTE_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         load,
    input  logic [W-1:0] load_byte,
    input  beat_t        beat_in,
    output beat_t        beat_out,
    output logic         busy
);
    localparam int LW = $clog2(W + 1);

    logic [W-1:0]  sreg;
    logic [LW-1:0] left;

    assign busy = (left != '0);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            sreg <= '0;
            left <= '0;
        end else if (busy) begin
            sreg <= sreg >> 1;
            left <= left - 1'b1;
        end else if (load) begin
            sreg <= load_byte;
            left <= LW'(W);
        end
    end

    always_comb begin
        if (busy) begin
            beat_out.vld = 1'b1;
            beat_out.dat = sreg[0];
        end else begin
            beat_out = beat_in;
        end
    end
endmodule

// File: rtl/swcrc_sequencer.sv
module swcrc_sequencer
    import swcrc_pkg::*;
#(
    parameter int NDATA  = DATA_BITS,
    parameter int NFRAME = FRAME_BITS
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  clr,
    input  beat_t beat,
    output logic  crc_en,
    output logic  cmp_en,
    output logic  last
);
    localparam int CW = $clog2(NFRAME + 1);

    logic [CW-1:0] cnt;
    phase_e        phase;
    logic          accept;

    assign accept = beat.vld && (phase != PH_DONE) && !clr;
    assign crc_en = accept && (phase == PH_DATA);
    assign cmp_en = accept && (phase == PH_CHECK);
    assign last   = cmp_en && (cnt == CW'(NFRAME - 1));

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt   <= '0;
            phase <= PH_DATA;
        end else if (accept) begin
            cnt <= cnt + 1'b1;
            if (crc_en && cnt == CW'(NDATA - 1))
                phase <= PH_CHECK;
            else if (last)
                phase <= PH_DONE;
        end
    end
endmodule

// File: rtl/swcrc_engine.sv
module swcrc_engine
    import swcrc_pkg::*;
#(
    parameter int               W    = CRC_W,
    parameter logic [W-1:0]     POLY = POLY_REFL
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         en,
    input  logic         d,
    output logic [W-1:0] crc
);
    always_ff @(posedge clk) begin
        if (rst || clr)
            crc <= '0;
        else if (en)
            crc <= crc_next(crc, d, POLY);
    end
endmodule

// File: rtl/swcrc_compare.sv
module swcrc_compare
    import swcrc_pkg::*;
#(
    parameter int W = CRC_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         en,
    input  logic         last,
    input  logic         d,
    input  logic [W-1:0] computed,
    output logic         done,
    output logic         match
);
    logic [W-1:0] rx;
    logic [W-1:0] rx_next;

    assign rx_next = {d, rx[W-1:1]};

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            rx    <= '0;
            done  <= 1'b0;
            match <= 1'b0;
        end else if (en) begin
            rx <= rx_next;
            if (last) begin
                done  <= 1'b1;
                match <= (rx_next == computed);
            end
        end
    end
endmodule

// File: rtl/serial_crc_checker.sv
module serial_crc_checker
    import swcrc_pkg::*;
#(
    parameter int NDATA = DATA_BITS
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              bit_vld,
    input  logic              bit_in,
    input  logic              byte_vld,
    input  logic [BYTE_W-1:0] byte_in,
    output logic              byte_busy,
    output logic [CRC_W-1:0]  crc_val,
    output logic              done,
    output logic              match
);
    localparam int NFRAME = NDATA + CRC_W;

    beat_t raw_beat;
    beat_t beat;
    logic  crc_en;
    logic  cmp_en;
    logic  last;

    assign raw_beat.vld = bit_vld;
    assign raw_beat.dat = bit_in;

    swcrc_byte_feeder #(.W(BYTE_W)) u_feed (
        .clk(clk), .rst(rst), .clr(clr),
        .load(byte_vld), .load_byte(byte_in),
        .beat_in(raw_beat), .beat_out(beat), .busy(byte_busy)
    );

    swcrc_sequencer #(.NDATA(NDATA), .NFRAME(NFRAME)) u_seq (
        .clk(clk), .rst(rst), .clr(clr), .beat(beat),
        .crc_en(crc_en), .cmp_en(cmp_en), .last(last)
    );

    swcrc_engine #(.W(CRC_W), .POLY(POLY_REFL)) u_crc (
        .clk(clk), .rst(rst), .clr(clr),
        .en(crc_en), .d(beat.dat), .crc(crc_val)
    );

    swcrc_compare #(.W(CRC_W)) u_cmp (
        .clk(clk), .rst(rst), .clr(clr),
        .en(cmp_en), .last(last), .d(beat.dat),
        .computed(crc_val), .done(done), .match(match)
    );
endmodule

// File: rtl/swcrc_checker.sv
module swcrc_checker
    import swcrc_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             clr,
    input logic             bit_vld,
    input logic             byte_vld,
    input logic             byte_busy,
    input logic [CRC_W-1:0] crc_val,
    input logic             done,
    input logic             match
);
    AST_RESET_STATE: assert property (@(posedge clk)
        rst |=> (crc_val == '0 && !done && !match && !byte_busy)); // R1

    AST_CLEAR_STATE: assert property (@(posedge clk) disable iff (rst)
        clr |=> (crc_val == '0 && !done && !match && !byte_busy)); // R7

    AST_MATCH_NEEDS_DONE: assert property (@(posedge clk) disable iff (rst)
        match |-> done); // R5

    AST_DONE_FROZEN: assert property (@(posedge clk) disable iff (rst)
        (done && !clr) |=> (done && $stable(match) && $stable(crc_val))); // R6

    AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (rst)
        (!clr && !bit_vld && !byte_vld && !byte_busy)
            |=> ($stable(crc_val) && $stable(done) && $stable(match))); // R10

    AST_LOAD_STARTS: assert property (@(posedge clk) disable iff (rst)
        (byte_vld && !byte_busy && !clr) |=> byte_busy); // R8
endmodule

bind serial_crc_checker swcrc_checker u_swcrc_chk (
    .clk(clk), .rst(rst), .clr(clr), .bit_vld(bit_vld),
    .byte_vld(byte_vld), .byte_busy(byte_busy),
    .crc_val(crc_val), .done(done), .match(match)
);

// File: tb/sim_serial_crc_checker.sv
module sim_serial_crc_checker;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       clr = 1'b0;
    logic       bit_vld = 1'b0;
    logic       bit_in = 1'b0;
    logic       byte_vld = 1'b0;
    logic [7:0] byte_in = 8'h00;
    logic       byte_busy;
    logic [7:0] crc_val;
    logic       done;
    logic       match;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    serial_crc_checker u0 (
        .clk(clk), .rst(rst), .clr(clr), .bit_vld(bit_vld), .bit_in(bit_in),
        .byte_vld(byte_vld), .byte_in(byte_in), .byte_busy(byte_busy),
        .crc_val(crc_val), .done(done), .match(match)
    );

    function automatic logic [7:0] m_step(input logic [7:0] c, input logic d);
        logic t;
        t = c[0] ^ d;
        c = {1'b0, c[7:1]};
        if (t) c = c ^ 8'h8C;
        return c;
    endfunction

    function automatic logic [7:0] m_byte(input logic [7:0] c, input logic [7:0] b);
        for (int i = 0; i < 8; i++) c = m_step(c, b[i]);
        return c;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic report();
        if (!finished) begin
            finished = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    task automatic send_bit(input logic b);
        @(negedge clk); bit_vld = 1'b1; bit_in = b;
        @(negedge clk); bit_vld = 1'b0;
    endtask

    task automatic send_byte_bits(input logic [7:0] b);
        for (int i = 0; i < 8; i++) send_bit(b[i]);
    endtask

    task automatic send_byte_load(input logic [7:0] b);
        @(negedge clk); byte_vld = 1'b1; byte_in = b;
        @(negedge clk); byte_vld = 1'b0;
        repeat (8) @(negedge clk);
    endtask

    task automatic do_clear();
        @(negedge clk); clr = 1'b1;
        @(negedge clk); clr = 1'b0;
    endtask

    logic [7:0] code [0:7];

    task automatic t_reset();
        check("R1 crc", crc_val, 8'h00);
        check("R1 done", done, 1'b0);
        check("R1 match", match, 1'b0);
        check("R1 busy", byte_busy, 1'b0);
    endtask

    task automatic t_good_bitwise();
        logic [7:0] m;
        do_clear();
        send_bit(1'b1);
        check("R2 first bit", crc_val, m_step(8'h00, 1'b1));
        send_bit(1'b0);
        check("R2 second bit", crc_val, m_step(m_step(8'h00, 1'b1), 1'b0));
        do_clear();
        m = 8'h00;
        for (int k = 0; k < 7; k++) begin
            send_byte_bits(code[k]);
            m = m_byte(m, code[k]);
        end
        check("R3 crc after 56", crc_val, m);
        check("R3 known vector", crc_val, 8'hA2);
        check("R5 not done at 56", done, 1'b0);
        send_byte_bits(code[7]);
        check("R4 crc held", crc_val, 8'hA2);
        check("R5 done", done, 1'b1);
        check("R5 match", match, 1'b1);
    endtask

    task automatic t_bad_crc();
        do_clear();
        for (int k = 0; k < 7; k++) send_byte_bits(code[k]);
        send_byte_bits(8'h45);
        check("R4 bad crc held", crc_val, 8'hA2);
        check("R5 bad done", done, 1'b1);
        check("R5 bad match", match, 1'b0);
    endtask

    task automatic t_after_done();
        send_bit(1'b1);
        send_byte_load(8'hFF);
        check("R6 crc frozen", crc_val, 8'hA2);
        check("R6 done held", done, 1'b1);
        check("R6 match held", match, 1'b0);
    endtask

    task automatic t_bytewise();
        logic [7:0] m;
        logic [7:0] fr [0:7];
        fr[0] = 8'h28; fr[1] = 8'h5A; fr[2] = 8'h3C; fr[3] = 8'h00;
        fr[4] = 8'hFF; fr[5] = 8'h81; fr[6] = 8'h7E;
        m = 8'h00;
        for (int k = 0; k < 7; k++) m = m_byte(m, fr[k]);
        fr[7] = m;
        do_clear();
        send_byte_load(fr[0]);
        check("R8 busy ended", byte_busy, 1'b0);
        check("R8 one byte", crc_val, m_byte(8'h00, fr[0]));
        for (int k = 1; k < 8; k++) send_byte_load(fr[k]);
        check("R8 crc", crc_val, m);
        check("R8 done", done, 1'b1);
        check("R8 match", match, 1'b1);
    endtask

    task automatic t_busy_ignore();
        do_clear();
        @(negedge clk); byte_vld = 1'b1; byte_in = 8'h6B;
        @(negedge clk); byte_vld = 1'b0;
        check("R8 busy high", byte_busy, 1'b1);
        bit_vld = 1'b1; bit_in = 1'b1; byte_vld = 1'b1; byte_in = 8'hFF;
        @(negedge clk); bit_vld = 1'b0; byte_vld = 1'b0;
        repeat (7) @(negedge clk);
        check("R9 busy done", byte_busy, 1'b0);
        check("R9 strobes ignored", crc_val, m_byte(8'h00, 8'h6B));
    endtask

    task automatic t_gaps_clear();
        do_clear();
        for (int i = 0; i < 8; i++) begin
            send_bit(code[1][i]);
            repeat (3) @(negedge clk);
        end
        check("R10 gaps", crc_val, m_byte(8'h00, code[1]));
        repeat (5) @(negedge clk);
        check("R10 idle", crc_val, m_byte(8'h00, code[1]));
        @(negedge clk); clr = 1'b1; bit_vld = 1'b1; bit_in = 1'b1;
        @(negedge clk); clr = 1'b0; bit_vld = 1'b0;
        check("R7 clear wins", crc_val, 8'h00);
        for (int k = 0; k < 8; k++) send_byte_bits(code[k]);
        check("R7 fresh frame", match, 1'b1);
    endtask

    initial begin
        code[0] = 8'h02; code[1] = 8'h1C; code[2] = 8'hB8; code[3] = 8'h01;
        code[4] = 8'h00; code[5] = 8'h00; code[6] = 8'h00; code[7] = 8'hA2;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_good_bitwise();
        t_bad_crc();
        t_after_done();
        t_bytewise();
        t_busy_ignore();
        t_gaps_clear();
        report();
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        report();
    end
endmodule